// File: doc/BRIEF.md
# Storage Key and Low-Address Protection Checker

This block decides whether one storage access may go ahead. For each request it takes the access type (fetch or store), the key of the requester, the storage key and fetch-protect bit of the addressed block, the logical address before translation, the enable of the low-address store ban, and a flag that marks the store as exempt from that ban. Exempt stores are those the machine makes on its own behalf, such as interruption and status saving, logouts, timer updates and channel input. One clock after the request it reports whether a protection exception applies.

The block checks the key and the low-address ban separately. A store needs a key match, and it must not fall in the protected low range while the ban is on. A fetch with a key mismatch is allowed only when the block is not fetch-protected. A probe request runs the same checks but never raises an exception. Instead it returns a two-bit code that tells whether the location can be both fetched and stored, fetched only, or not touched at all. The key array, address translation and the memory access itself stay outside the block.

Top module: `storage_protect_check`

## Requirements
- R1: While reset is asserted and in the cycle after it, rspValid, protFault and probeCode are all 0.
- R2: An access key matches when it equals the block's storage key, or when it is 0. Key 0 matches every storage key.
- R3: An access request (reqProbe=0) with reqIsStore=1 raises protFault unless the key matches and the low-address ban does not apply.
- R4: An access request with reqIsStore=0 raises protFault exactly when the key does not match and blockFetchProt=1.
- R5: The low-address ban applies to a store when lowProtEnable=1, exemptStore=0 and the logical address is below LOW_LIMIT (512 by default). It raises protFault for such a store even with access key 0.
- R6: exemptStore=1 lifts only the low-address ban. The key rule of R3 still holds for an exempt store.
- R7: A probe request (reqProbe=1) never raises protFault. probeCode is 0 when a store would be allowed, 1 when only a fetch would be allowed, and 2 when neither would. For a probe, reqIsStore is ignored and the store verdict uses the R3/R5/R6 rules.
- R8: Each request sampled with reqValid=1 at a clock edge gives rspValid=1 after that edge. With no request, rspValid, protFault and probeCode return to 0 after the next edge. In access mode probeCode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqProbe | input | 1 | 1: probe request, 0: access request |
| reqIsStore | input | 1 | Access type: 1 store, 0 fetch |
| accessKey | input | KEY_W | Key of the requester |
| blockKey | input | KEY_W | Storage key of the addressed block |
| blockFetchProt | input | 1 | Fetch-protect bit of the addressed block |
| logicalAddr | input | ADDR_W | Address before translation |
| lowProtEnable | input | 1 | Enables the low-address store ban |
| exemptStore | input | 1 | Store is exempt from the low-address ban |
| rspValid | output | 1 | Result of the previous cycle's request is valid |
| protFault | output | 1 | Protection exception for an access request |
| probeCode | output | 2 | Condition code of a probe request |

## Verification
The bench builds the block with KEY_W=4, ADDR_W=12 and LOW_LIMIT=512. With these values every pair of access key and storage key can be swept against every combination of fetch-protect, access type, probe mode, exemption and ban enable. Addresses are taken at the low range edges 0, 256, 511 and 512 and at the top address. This covers the key-zero match, exempt stores to low addresses and the condition codes of all three probe outcomes, each checked against an arithmetic model.

// File: rtl/storprot_pkg.sv
package storprot_pkg;

  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // latch a verdict this edge
    logic probe;     // verdict is a probe code, not an exception
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    CC_BOTH  = 2'd0,
    CC_FETCH = 2'd1,
    CC_NONE  = 2'd2
  } probeCode_e;

endpackage

// File: rtl/sp_control.sv
module sp_control
  import storprot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqProbe,
  output ctlStrobes_t strobes,
  output logic        rspValid
);

  always_comb begin
    strobes.capture = reqValid;
    strobes.probe   = reqValid & reqProbe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  // R8: one response per request, one cycle later
  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_rsp_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import storprot_pkg::*;
#(
  parameter int KEY_W     = 4,
  parameter int ADDR_W    = 24,
  parameter int LOW_LIMIT = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              reqIsStore,
  input  logic [KEY_W-1:0]  accessKey,
  input  logic [KEY_W-1:0]  blockKey,
  input  logic              blockFetchProt,
  input  logic [ADDR_W-1:0] logicalAddr,
  input  logic              lowProtEnable,
  input  logic              exemptStore,
  output logic              protFault,
  output logic [1:0]        probeCode
);

  localparam logic [ADDR_W-1:0] LowBound = ADDR_W'(LOW_LIMIT);
  localparam logic [KEY_W-1:0]  MasterKey = '0;

  logic keyMatch, inLowRange, lowBan, storeOk, fetchOk, faultNext;
  probeCode_e codeNext;

  always_comb begin
    keyMatch   = (accessKey == MasterKey) || (accessKey == blockKey);
    inLowRange = logicalAddr < LowBound;
    lowBan     = lowProtEnable & ~exemptStore & inLowRange;
    storeOk    = keyMatch & ~lowBan;
    fetchOk    = keyMatch | ~blockFetchProt;
    faultNext  = reqIsStore ? ~storeOk : ~fetchOk;
    if (storeOk)      codeNext = CC_BOTH;
    else if (fetchOk) codeNext = CC_FETCH;
    else              codeNext = CC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.capture) begin
      protFault <= 1'b0;
      probeCode <= 2'd0;
    end else if (strobes.probe) begin
      protFault <= 1'b0;
      probeCode <= codeNext;
    end else begin
      protFault <= faultNext;
      probeCode <= 2'd0;
    end
  end

  // R5: a banned low store faults whatever the key
  assert_low_store_faults_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.probe && reqIsStore && lowProtEnable &&
     !exemptStore && (logicalAddr < LowBound)) |=> protFault);

  // R2: key zero may always fetch
  assert_key_zero_fetch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.probe && !reqIsStore && (accessKey == MasterKey))
    |=> !protFault);

  // R7: probes never raise an exception
  assert_probe_no_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.probe |=> (!protFault && probeCode != 2'd3));

  // R8: idle cycle leaves outputs quiet
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> (!protFault && probeCode == 2'd0));

endmodule

// File: rtl/storage_protect_check.sv
module storage_protect_check
  import storprot_pkg::*;
#(
  parameter int KEY_W     = 4,
  parameter int ADDR_W    = 24,
  parameter int LOW_LIMIT = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqProbe,
  input  logic              reqIsStore,
  input  logic [KEY_W-1:0]  accessKey,
  input  logic [KEY_W-1:0]  blockKey,
  input  logic              blockFetchProt,
  input  logic [ADDR_W-1:0] logicalAddr,
  input  logic              lowProtEnable,
  input  logic              exemptStore,
  output logic              rspValid,
  output logic              protFault,
  output logic [1:0]        probeCode
);

  ctlStrobes_t strobes;

  sp_control uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqProbe (reqProbe),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  sp_datapath #(
    .KEY_W     (KEY_W),
    .ADDR_W    (ADDR_W),
    .LOW_LIMIT (LOW_LIMIT)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .reqIsStore     (reqIsStore),
    .accessKey      (accessKey),
    .blockKey       (blockKey),
    .blockFetchProt (blockFetchProt),
    .logicalAddr    (logicalAddr),
    .lowProtEnable  (lowProtEnable),
    .exemptStore    (exemptStore),
    .protFault      (protFault),
    .probeCode      (probeCode)
  );

endmodule

// File: tb/sim_storage_protect_check.sv
module sim_storage_protect_check;

  localparam int KW = 4;
  localparam int AW = 12;
  localparam int LL = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqProbe = 1'b0, reqIsStore = 1'b0;
  logic [KW-1:0] accessKey = '0, blockKey = '0;
  logic blockFetchProt = 1'b0, lowProtEnable = 1'b0, exemptStore = 1'b0;
  logic [AW-1:0] logicalAddr = '0;
  logic rspValid, protFault;
  logic [1:0] probeCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  storage_protect_check #(.KEY_W(KW), .ADDR_W(AW), .LOW_LIMIT(LL)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqProbe(reqProbe),
    .reqIsStore(reqIsStore), .accessKey(accessKey), .blockKey(blockKey),
    .blockFetchProt(blockFetchProt), .logicalAddr(logicalAddr),
    .lowProtEnable(lowProtEnable), .exemptStore(exemptStore),
    .rspValid(rspValid), .protFault(protFault), .probeCode(probeCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (ak=%0d bk=%0d fp=%0d st=%0d pr=%0d lpe=%0d ex=%0d a=%0d)",
               tag, act, exp, accessKey, blockKey, blockFetchProt, reqIsStore,
               reqProbe, lowProtEnable, exemptStore, logicalAddr);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic doReq(input bit pr, input bit st, input int ak, input int bk,
                       input bit fp, input int addr, input bit lpe, input bit ex);
    bit match, ban, sOk, fOk, expFault;
    int expCode;
    string tag;
    reqValid = 1'b1; reqProbe = pr; reqIsStore = st;
    accessKey = KW'(ak); blockKey = KW'(bk); blockFetchProt = fp;
    logicalAddr = AW'(addr); lowProtEnable = lpe; exemptStore = ex;
    match = (ak == 0) || (ak == bk);
    ban   = lpe && !ex && (addr < LL);
    sOk   = match && !ban;
    fOk   = match || !fp;
    expCode  = sOk ? 0 : (fOk ? 1 : 2);
    expFault = pr ? 1'b0 : (st ? !sOk : !fOk);
    if (pr)                         tag = "R7";
    else if (st && ban)             tag = "R5";
    else if (st && ex && lpe && addr < LL) tag = "R6";
    else if (st)                    tag = "R3";
    else if (ak == 0)               tag = "R2";
    else                            tag = "R4";
    @(negedge clk);
    check("R8 rspValid", int'(rspValid), 1);
    check(tag, int'(protFault), int'(expFault));
    check(pr ? "R7 code" : "R8 code", int'(probeCode), pr ? expCode : 0);
  endtask

  initial begin
    int addrs[5] = '{0, 256, 511, 512, 4095};
    repeat (3) @(negedge clk);
    check("R1 rspValid", int'(rspValid), 0);
    check("R1 protFault", int'(protFault), 0);
    check("R1 probeCode", int'(probeCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rspValid after", int'(rspValid), 0);
    check("R1 protFault after", int'(protFault), 0);
    for (int ak = 0; ak < 16; ak++)
      for (int bk = 0; bk < 16; bk++)
        for (int m = 0; m < 32; m++)
          for (int ai = 0; ai < 5; ai++)
            doReq(m[0], m[1], ak, bk, m[2], addrs[ai], m[3], m[4]);
    // idle after a faulting request
    doReq(1'b0, 1'b1, 3, 4, 1'b1, 4095, 1'b0, 1'b0);
    reqValid = 1'b0;
    @(negedge clk);
    check("R8 idle rspValid", int'(rspValid), 0);
    check("R8 idle protFault", int'(protFault), 0);
    check("R8 idle probeCode", int'(probeCode), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule